// File: doc/BRIEF.md
# Dual-Half Registered Bus Transceiver Core

This block holds the control and data-path logic of a 16-bit bidirectional bus transceiver. The transceiver is split into two independent 8-bit halves. Each half has two storage paths, one from port A to port B and one from port B to port A. Each path's storage stage combines a transparent latch and an edge-triggered register under one latch enable and the shared clock `cp_i`. The stage therefore works as a flow-through path, a latched hold or a registered stage. Pads appear as separate input, output and output-enable signals.

Tri-state enables for both ports come from three things: per-half, per-direction active-low enables, one active-low master enable shared by both halves, and a power-good input that keeps every output off until supply is valid. Port A inputs model bus hold: while a half's input-valid flag is low, the last valid value is kept. A debug flag per half reports when both directions of that half are enabled at once. In that case only port B drives.

Top module: `dual_bus_xcvr`

## Requirements
- R1: Each half has its own latch enables and direction enables, and a control of one half has no effect on the data or enables of the other half. Half h occupies bits [8h+7:8h] of every data bus and bit h of every per-half control.
- R2: While a path's latch enable is 1, its output follows its input combinationally (transparent mode).
- R3: A 1-to-0 transition of a path's latch enable captures the input at that instant, and the output holds that value until the next rising `cp_i` edge, even if the input changes in between.
- R4: On a rising `cp_i` edge with the latch enable at 0, the path loads its input and holds it at its output until the next such edge or until the latch enable rises.
- R5: The B-to-A path of each half follows R2 to R4 using `leba_i`, `b_in_i` and `a_out_o`.
- R6: `b_oe_o[h]` is 1 exactly when `pwr_good_i`=1, `oe_ni`=0 and `oeab_ni[h]`=0. `a_oe_o[h]` is 1 exactly when `pwr_good_i`=1, `oe_ni`=0, `oeba_ni[h]`=0 and `b_oe_o[h]`=0.
- R7: With `oe_ni`=1, all of `a_oe_o` and `b_oe_o` are 0.
- R8: With `pwr_good_i`=0, all output enables are 0. When `pwr_good_i` rises, the enables follow R6 in the same cycle, without waiting for a clock edge.
- R9: `contention_o[h]` is 1 exactly when both directions of half h would be enabled (`pwr_good_i`=1, `oe_ni`=0, `oeab_ni[h]`=0, `oeba_ni[h]`=0). Port B keeps its enable in that case, and port A does not drive.
- R10: While `a_valid_i[h]`=0, the A-to-B path of half h sees the last port A value that was present while `a_valid_i[h]` was 1.
- R11: While `rst_ni`=0, all storage and the bus-hold value clear to zero. With the latch enables at 0 after reset, both data outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cp_i | input | 1 | Shared clock for the registered mode of all four paths |
| rst_ni | input | 1 | Active-low asynchronous reset |
| oe_ni | input | 1 | Master output enable, active low |
| pwr_good_i | input | 1 | Supply valid; 0 forces all enables off |
| leab_i | input | 2 | A-to-B latch enable per half |
| leba_i | input | 2 | B-to-A latch enable per half |
| oeab_ni | input | 2 | Port B drive enable per half, active low |
| oeba_ni | input | 2 | Port A drive enable per half, active low |
| a_in_i | input | 16 | Port A pad input |
| a_valid_i | input | 2 | Port A input valid per half; 0 selects the held value |
| a_out_o | output | 16 | Port A pad output data |
| a_oe_o | output | 2 | Port A pad output enable per half |
| b_in_i | input | 16 | Port B pad input |
| b_out_o | output | 16 | Port B pad output data |
| b_oe_o | output | 2 | Port B pad output enable per half |
| contention_o | output | 2 | Both directions of a half requested at once |

## Verification
Output enables and the contention flag are combinational. The data outputs are also combinational in transparent and latched mode. The bench checks all of these 1 ns after changing the inputs, in the same cycle. A registered load shows up right after the rising `cp_i` edge. Inputs change only at the falling edge, so each registered result is checked half a cycle after its rising edge. The case where the latch enable falls 1 ns before a rising edge, and the case where the input changes between that fall and the next edge, both have directed checks timed inside that cycle.

// File: rtl/dbx_pkg.sv
package dbx_pkg;
  typedef enum logic [1:0] {
    MODE_FLOW = 2'd0,
    MODE_HOLD = 2'd1,
    MODE_REG  = 2'd2
  } path_mode_e;
endpackage

// File: rtl/dbx_store.sv
module dbx_store
  import dbx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         cp_i,
  input  logic         rst_ni,
  input  logic         le_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] lat_q;
  logic [W-1:0] reg_q;
  logic         reg_sel_q;
  path_mode_e   mode;

  always_latch begin
    if (!rst_ni) lat_q = '0;
    else if (le_i) lat_q = d_i;
  end

  always_ff @(posedge cp_i or negedge rst_ni) begin
    if (!rst_ni) reg_q <= '0;
    else if (!le_i) reg_q <= d_i;
  end

  // register output valid from the first clock edge after the enable falls
  always_ff @(posedge cp_i or negedge rst_ni or posedge le_i) begin
    if (!rst_ni) reg_sel_q <= 1'b0;
    else if (le_i) reg_sel_q <= 1'b0;
    else reg_sel_q <= 1'b1;
  end

  always_comb begin
    if (le_i) mode = MODE_FLOW;
    else if (reg_sel_q) mode = MODE_REG;
    else mode = MODE_HOLD;
  end

  always_comb begin
    unique case (mode)
      MODE_FLOW: q_o = d_i;
      MODE_REG:  q_o = reg_q;
      default:   q_o = lat_q;
    endcase
  end

  // R4: registered load visible until the next edge
  a_r4_clocked_load: assert property (@(posedge cp_i) disable iff (!rst_ni)
    !le_i |=> (le_i || q_o == $past(d_i)));
endmodule

// File: rtl/dbx_bus_hold.sv
module dbx_bus_hold #(
  parameter int W = 8
) (
  input  logic         cp_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] eff_o
);
  logic [W-1:0] hold_q;

  always_latch begin
    if (!rst_ni) hold_q = '0;
    else if (valid_i) hold_q = pad_i;
  end

  assign eff_o = valid_i ? pad_i : hold_q;

  // R10: undriven pad keeps its value
  a_r10_hold_stable: assert property (@(posedge cp_i) disable iff (!rst_ni)
    !valid_i |=> (valid_i || $stable(eff_o)));
endmodule

// File: rtl/dbx_half.sv
module dbx_half #(
  parameter int W = 8
) (
  input  logic         cp_i,
  input  logic         rst_ni,
  input  logic         oe_ni,
  input  logic         pwr_good_i,
  input  logic         leab_i,
  input  logic         leba_i,
  input  logic         oeab_ni,
  input  logic         oeba_ni,
  input  logic [W-1:0] a_in_i,
  input  logic         a_valid_i,
  output logic [W-1:0] a_out_o,
  output logic         a_oe_o,
  input  logic [W-1:0] b_in_i,
  output logic [W-1:0] b_out_o,
  output logic         b_oe_o,
  output logic         contention_o
);
  logic [W-1:0] a_eff;
  logic         drive_ok;
  logic         want_b;
  logic         want_a;

  dbx_bus_hold #(.W(W)) u_hold (
    .cp_i   (cp_i),
    .rst_ni (rst_ni),
    .valid_i(a_valid_i),
    .pad_i  (a_in_i),
    .eff_o  (a_eff)
  );

  dbx_store #(.W(W)) u_ab (
    .cp_i  (cp_i),
    .rst_ni(rst_ni),
    .le_i  (leab_i),
    .d_i   (a_eff),
    .q_o   (b_out_o)
  );

  dbx_store #(.W(W)) u_ba (
    .cp_i  (cp_i),
    .rst_ni(rst_ni),
    .le_i  (leba_i),
    .d_i   (b_in_i),
    .q_o   (a_out_o)
  );

  assign drive_ok     = pwr_good_i & ~oe_ni;
  assign want_b       = drive_ok & ~oeab_ni;
  assign want_a       = drive_ok & ~oeba_ni;
  assign b_oe_o       = want_b;
  assign a_oe_o       = want_a & ~want_b;  // port B wins
  assign contention_o = want_a & want_b;

  a_r9_no_dual_drive: assert property (@(posedge cp_i) disable iff (!rst_ni)
    !(a_oe_o && b_oe_o));
  a_r9_flag_b_wins: assert property (@(posedge cp_i) disable iff (!rst_ni)
    contention_o |-> (b_oe_o && !a_oe_o));
  a_r8_power_off: assert property (@(posedge cp_i) disable iff (!rst_ni)
    !pwr_good_i |-> (!a_oe_o && !b_oe_o && !contention_o));
  a_r7_master_off: assert property (@(posedge cp_i) disable iff (!rst_ni)
    oe_ni |-> (!a_oe_o && !b_oe_o));
endmodule

// File: rtl/dual_bus_xcvr.sv
module dual_bus_xcvr #(
  parameter int HALF_W   = 8,
  parameter int N_HALVES = 2,
  localparam int BUS_W   = HALF_W * N_HALVES
) (
  input  logic                cp_i,
  input  logic                rst_ni,
  input  logic                oe_ni,
  input  logic                pwr_good_i,
  input  logic [N_HALVES-1:0] leab_i,
  input  logic [N_HALVES-1:0] leba_i,
  input  logic [N_HALVES-1:0] oeab_ni,
  input  logic [N_HALVES-1:0] oeba_ni,
  input  logic [BUS_W-1:0]    a_in_i,
  input  logic [N_HALVES-1:0] a_valid_i,
  output logic [BUS_W-1:0]    a_out_o,
  output logic [N_HALVES-1:0] a_oe_o,
  input  logic [BUS_W-1:0]    b_in_i,
  output logic [BUS_W-1:0]    b_out_o,
  output logic [N_HALVES-1:0] b_oe_o,
  output logic [N_HALVES-1:0] contention_o
);
  for (genvar h = 0; h < N_HALVES; h++) begin : g_half
    dbx_half #(.W(HALF_W)) u_half (
      .cp_i        (cp_i),
      .rst_ni      (rst_ni),
      .oe_ni       (oe_ni),
      .pwr_good_i  (pwr_good_i),
      .leab_i      (leab_i[h]),
      .leba_i      (leba_i[h]),
      .oeab_ni     (oeab_ni[h]),
      .oeba_ni     (oeba_ni[h]),
      .a_in_i      (a_in_i[h*HALF_W +: HALF_W]),
      .a_valid_i   (a_valid_i[h]),
      .a_out_o     (a_out_o[h*HALF_W +: HALF_W]),
      .a_oe_o      (a_oe_o[h]),
      .b_in_i      (b_in_i[h*HALF_W +: HALF_W]),
      .b_out_o     (b_out_o[h*HALF_W +: HALF_W]),
      .b_oe_o      (b_oe_o[h]),
      .contention_o(contention_o[h])
    );
  end

  // R6: no half drives port B without power and master enable
  a_r6_b_gated: assert property (@(posedge cp_i) disable iff (!rst_ni)
    (b_oe_o != '0) |-> (pwr_good_i && !oe_ni));
endmodule

// File: tb/dual_bus_xcvr_tb.sv
module dual_bus_xcvr_tb;
  logic        cp = 1'b0;
  logic        rst_n = 1'b0;
  logic        oe_n, pg;
  logic [1:0]  leab, leba, oeab_n, oeba_n, a_valid;
  logic [15:0] a_in, b_in;
  logic [15:0] a_out, b_out;
  logic [1:0]  a_oe, b_oe, cont;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] m_lat [4];
  logic [7:0] m_ff  [4];
  logic       m_sel [4];
  logic [7:0] m_hold[2];

  always #10 cp = ~cp;

  dual_bus_xcvr u_dut (
    .cp_i(cp), .rst_ni(rst_n), .oe_ni(oe_n), .pwr_good_i(pg),
    .leab_i(leab), .leba_i(leba), .oeab_ni(oeab_n), .oeba_ni(oeba_n),
    .a_in_i(a_in), .a_valid_i(a_valid), .a_out_o(a_out), .a_oe_o(a_oe),
    .b_in_i(b_in), .b_out_o(b_out), .b_oe_o(b_oe), .contention_o(cont)
  );

  // path p = 2*half + dir, dir 0 = A to B, dir 1 = B to A
  function automatic logic le_of(int p);
    return (p % 2) ? leba[p/2] : leab[p/2];
  endfunction

  function automatic logic [7:0] d_of(int p);
    int h = p / 2;
    if (p % 2) return b_in[h*8 +: 8];
    return a_valid[h] ? a_in[h*8 +: 8] : m_hold[h];
  endfunction

  function automatic logic [7:0] q_of(int p);
    if (le_of(p)) return d_of(p);
    return m_sel[p] ? m_ff[p] : m_lat[p];
  endfunction

  function automatic string dtag(int p);
    if (p % 2) return "R5";
    if (le_of(p)) return "R2";
    return m_sel[p] ? "R4" : "R3";
  endfunction

  function automatic string etag();
    if (!pg) return "R8";
    if (oe_n) return "R7";
    return "R6";
  endfunction

  task automatic model_reset();
    for (int p = 0; p < 4; p++) begin
      m_lat[p] = '0; m_ff[p] = '0; m_sel[p] = 1'b0;
    end
    m_hold[0] = '0; m_hold[1] = '0;
  endtask

  task automatic model_comb();
    for (int h = 0; h < 2; h++) if (a_valid[h]) m_hold[h] = a_in[h*8 +: 8];
    for (int p = 0; p < 4; p++) if (le_of(p)) begin
      m_lat[p] = d_of(p); m_sel[p] = 1'b0;
    end
  endtask

  always @(posedge cp) if (rst_n) begin
    for (int p = 0; p < 4; p++) if (!le_of(p)) begin
      m_ff[p] = d_of(p); m_sel[p] = 1'b1;
    end
  end

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t got=%h exp=%h", tag, $time, got, exp);
    end
  endtask

  task automatic check_all(string ovr);
    for (int h = 0; h < 2; h++) begin
      logic eb, ea, ec;
      eb = pg & ~oe_n & ~oeab_n[h];
      ec = eb & pg & ~oe_n & ~oeba_n[h];
      ea = pg & ~oe_n & ~oeba_n[h] & ~eb;
      chk(ovr != "" ? ovr : dtag(2*h),   16'(b_out[h*8 +: 8]), 16'(q_of(2*h)));
      chk(ovr != "" ? ovr : dtag(2*h+1), 16'(a_out[h*8 +: 8]), 16'(q_of(2*h+1)));
      chk(ovr != "" ? ovr : etag(), 16'(b_oe[h]), 16'(eb));
      chk(ovr != "" ? ovr : (ec ? "R9" : etag()), 16'(a_oe[h]), 16'(ea));
      chk("R9", 16'(cont[h]), 16'(ec));
    end
  endtask

  task automatic settle_check(string ovr);
    model_comb();
    #1;
    check_all(ovr);
  endtask

  task automatic rand_step();
    logic [1:0] nab, nba;
    @(negedge cp);
    nab = leab; nba = leba;
    for (int h = 0; h < 2; h++) begin
      if ($urandom % 8 == 0) nab[h] = ~nab[h];
      if ($urandom % 8 == 0) nba[h] = ~nba[h];
    end
    for (int h = 0; h < 2; h++) begin
      logic fa, fb, nv, fv;
      fa = leab[h] & ~nab[h];
      fb = leba[h] & ~nba[h];
      nv = a_valid[h];
      if ($urandom % 6 == 0) nv = ~nv;
      if (fa) nv = a_valid[h];
      fv = a_valid[h] & ~nv;
      if (!fa && !fv && ($urandom % 2 == 0)) a_in[h*8 +: 8] = 8'($urandom);
      if (!fb && ($urandom % 2 == 0)) b_in[h*8 +: 8] = 8'($urandom);
      a_valid[h] = nv;
      if ($urandom % 5 == 0) oeab_n[h] = ~oeab_n[h];
      if ($urandom % 5 == 0) oeba_n[h] = ~oeba_n[h];
    end
    leab = nab; leba = nba;
    if ($urandom % 40 == 0) pg = ~pg;
    if ($urandom % 30 == 0) oe_n = ~oe_n;
    settle_check("");
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7151));
    oe_n = 1'b1; pg = 1'b0; leab = '0; leba = '0;
    oeab_n = 2'b11; oeba_n = 2'b11; a_valid = 2'b11;
    a_in = 16'h5a3c; b_in = 16'hc3a5;
    model_reset();
    repeat (3) @(posedge cp);
    #1 check_all("R11");
    @(negedge cp) rst_n = 1'b1;
    #1 check_all("R11");

    // power-good released while enables asserted
    @(negedge cp);
    oe_n = 1'b0; oeab_n = 2'b10; oeba_n = 2'b01;
    settle_check("R8");
    pg = 1'b1;
    settle_check("R8");

    // transparent on half 0 only, half 1 must not move
    a_in = 16'h0011; leab = 2'b01;
    settle_check("R2");
    a_in = 16'h0022;
    settle_check("R1");

    // latched: fall then change input before the edge
    @(negedge cp); #1;
    leab[0] = 1'b0;
    settle_check("R3");
    a_in[7:0] = 8'h77;
    settle_check("R3");
    @(negedge cp);
    settle_check("R4");

    // enable falls 1 ns before a rising edge
    leab[0] = 1'b1; leba[1] = 1'b1; b_in = 16'h9900;
    settle_check("R5");
    @(negedge cp); #9;
    leab[0] = 1'b0; leba[1] = 1'b0;
    settle_check("R3");
    @(negedge cp);
    a_in[7:0] = 8'h13; b_in[15:8] = 8'h31;
    settle_check("R4");

    // bus hold
    leab[1] = 1'b1; a_in[15:8] = 8'he1;
    settle_check("R10");
    @(negedge cp);
    a_valid[1] = 1'b0;
    settle_check("R10");
    a_in[15:8] = 8'h1e;
    settle_check("R10");

    // contention and master disable
    oeab_n = 2'b00; oeba_n = 2'b00;
    settle_check("R9");
    oe_n = 1'b1;
    settle_check("R7");
    oe_n = 1'b0;
    settle_check("R6");

    for (int i = 0; i < 1500; i++) rand_step();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule